// File: doc/BRIEF.md
# Pixel Blitter

The block is a rectangle copy engine for a frame buffer that packs two 4-bit pixels into each byte. Software loads a source base, a destination base, a width-by-height size and a solid colour, then writes a control byte; that write starts the copy. The engine then works on its own while the processor carries on, and it signals the end of the copy with a one-cycle interrupt pulse.

For each byte of the rectangle, the engine reads one source byte and then writes one destination byte. On the way the pixel path can shift the image right by one pixel, replace pixels with a constant colour, skip pixels whose source value is zero, and block writes to the even or the odd pixel of each byte. Reads and writes each pick serial or block addressing on their own. A half-rate mode holds every write back until a slow clock enable has been seen.

Top module: `pixel_blitter`

## Requirements
- R1: After reset `busy`, `memReq` and `doneIrq` are low, and `memReq` stays low whenever `busy` is low.
- R2: `regSel` picks the register: 0 source base, 1 destination base, 2 size (width in bits [DIM_W-1:0], height in bits [2*DIM_W-1:DIM_W]), 3 colour (bits [3:0]), 4 control (bits [7:0]). A write to register 4 starts an operation. Any register write that arrives while `busy` is high has no effect, and a later start uses the earlier values.
- R3: The rectangle is walked as `height` lines of `width` bytes. Line i, step j, with serial format selected, uses offset i*width + j from the base.
- R4: With block format selected, the offset is j*STRIDE + i. Control bit 0 picks the format for reads and bit 1 the format for writes (0 serial, 1 block), each on its own.
- R5: Bits [7:4] of a byte are the even pixel and bits [3:0] the odd pixel. Control bit 6 stops writes to the even nibble and bit 7 stops writes to the odd nibble (`memNibbleEn[1]` and `memNibbleEn[0]` low).
- R6: With control bits 7 and 6 both set, no nibble is written, yet the operation takes exactly as many cycles as the same copy with neither bit set.
- R7: Control bit 5 makes the written byte {low nibble of the previous source byte in the line, high nibble of the current source byte}. The carried nibble is zero at the start of every line.
- R8: Control bit 4 replaces every written pixel with the colour register value.
- R9: Control bit 3 blocks the write of any pixel whose value after the shift, and before colour substitution, is zero.
- R10: With control bit 2 set, a write request starts only in the cycle after one in which `slowTick` was high.
- R11: Each byte is one read followed by one write. `memReq` stays high, with `memAddr` unchanged, until the cycle in which `memAck` is seen.
- R12: After the last write is acknowledged, `doneIrq` is high for exactly one cycle and `busy` falls in the next cycle.
- R13: A start with zero width or zero height makes no memory access and still gives the `doneIrq` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 3 | Register select |
| regWdata | input | ADDR_W | Register write data |
| slowTick | input | 1 | Slow clock enable for half-rate writes |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 for a write, 0 for a read |
| memAddr | output | ADDR_W | Byte address |
| memWdata | output | 8 | Write data |
| memNibbleEn | output | 2 | Write enable per nibble ([1] even, [0] odd) |
| memRdata | input | 8 | Read data, valid with memAck |
| memAck | input | 1 | Memory acknowledge |
| busy | output | 1 | Operation in progress |
| doneIrq | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with ADDR_W=12, DIM_W=6 and STRIDE=16. At this size a 4 KB memory model covers the whole address space, and every one of the 256 control byte values can be run against small rectangles. After each run the full memory is compared with an arithmetic model. The small stride keeps block-format rectangles disjoint from the source area, so every mix of read and write formats, shift, substitution, transparency and masking is reached, along with the busy-write, zero-size and timing cases.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef struct packed {
    logic launch;   // clear walkers, latch start
    logic capture;  // take the read byte
    logic advance;  // step to next byte
  } blitStrobes_t;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_SYNC, S_WRITE, S_DONE
  } blitState_t;

  localparam logic [2:0] SEL_SRC    = 3'd0;
  localparam logic [2:0] SEL_DST    = 3'd1;
  localparam logic [2:0] SEL_SIZE   = 3'd2;
  localparam logic [2:0] SEL_COLOUR = 3'd3;
  localparam logic [2:0] SEL_CTRL   = 3'd4;
endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         launchReq,
  input  logic         sizeZero,
  input  logic         halfRate,
  input  logic         slowTick,
  input  logic         memAck,
  input  logic         lastStep,
  output blitStrobes_t strb,
  output logic         memReq,
  output logic         memWe,
  output logic         busy,
  output logic         doneIrq
);
  blitState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      S_IDLE: if (launchReq) begin
        strb.launch = 1'b1;
        nextState   = sizeZero ? S_DONE : S_READ;
      end
      S_READ: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.capture = 1'b1;
          nextState    = halfRate ? S_SYNC : S_WRITE;
        end
      end
      S_SYNC: if (slowTick) nextState = S_WRITE;
      S_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          strb.advance = 1'b1;
          nextState    = lastStep ? S_DONE : S_READ;
        end
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy    = (state != S_IDLE);
  assign doneIrq = (state == S_DONE);
endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 8,
  parameter int STRIDE = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  blitStrobes_t      strb,
  input  logic              writePhase,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [1:0]        memNibbleEn,
  output logic              lastStep,
  output logic              sizeZero,
  output logic              halfRate
);
  localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(STRIDE);
  localparam int NIBBLES = 2;

  logic [ADDR_W-1:0] srcBase, dstBase, linOff;
  logic [DIM_W-1:0]  widthReg, heightReg, colIdx, rowIdx;
  logic [3:0]        colourReg, carryNib;
  logic [7:0]        ctrlReg, rdByte, shifted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcBase <= '0; dstBase <= '0; widthReg <= '0; heightReg <= '0;
      colourReg <= '0; ctrlReg <= '0;
    end else if (regWe) begin
      unique case (regSel)
        SEL_SRC:    srcBase <= regWdata;
        SEL_DST:    dstBase <= regWdata;
        SEL_SIZE: begin
          widthReg  <= regWdata[DIM_W-1:0];
          heightReg <= regWdata[2*DIM_W-1:DIM_W];
        end
        SEL_COLOUR: colourReg <= regWdata[3:0];
        SEL_CTRL:   ctrlReg <= regWdata[7:0];
        default: ;
      endcase
    end
  end

  wire endOfLine = (colIdx == widthReg - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN || strb.launch) begin
      colIdx <= '0; rowIdx <= '0; linOff <= '0; carryNib <= '0; rdByte <= '0;
    end else begin
      if (strb.capture) rdByte <= memRdata;
      if (strb.advance) begin
        linOff <= linOff + 1'b1;
        if (endOfLine) begin
          colIdx   <= '0;
          rowIdx   <= rowIdx + 1'b1;
          carryNib <= '0;
        end else begin
          colIdx   <= colIdx + 1'b1;
          carryNib <= rdByte[3:0];
        end
      end
    end
  end

  logic [ADDR_W-1:0] blockOff, srcOff, dstOff;
  always_comb begin
    blockOff = ADDR_W'(colIdx) * STRIDE_V + ADDR_W'(rowIdx);
    srcOff   = ctrlReg[0] ? blockOff : linOff;
    dstOff   = ctrlReg[1] ? blockOff : linOff;
    memAddr  = writePhase ? (dstBase + dstOff) : (srcBase + srcOff);
    shifted  = ctrlReg[5] ? {carryNib, rdByte[7:4]} : rdByte;
  end

  // nibble 1 = even pixel (mask bit 6), nibble 0 = odd pixel (mask bit 7)
  for (genvar n = 0; n < NIBBLES; n++) begin : gNib
    wire [3:0] pix = shifted[4*n +: 4];
    assign memNibbleEn[n]    = !ctrlReg[7-n] && !(ctrlReg[3] && (pix == 4'd0));
    assign memWdata[4*n +: 4] = ctrlReg[4] ? colourReg : pix;
  end

  assign lastStep = endOfLine && (rowIdx == heightReg - 1'b1);
  assign sizeZero = (widthReg == '0) || (heightReg == '0);
  assign halfRate = ctrlReg[2];
endmodule

// File: rtl/pixel_blitter.sv
module pixel_blitter
  import blit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 8,
  parameter int STRIDE = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              slowTick,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [1:0]        memNibbleEn,
  input  logic [7:0]        memRdata,
  input  logic              memAck,
  output logic              busy,
  output logic              doneIrq
);
  blitStrobes_t strb;
  logic lastStep, sizeZero, halfRate;
  wire  acceptWe  = regWe && !busy;
  wire  launchReq = acceptWe && (regSel == SEL_CTRL);

  blit_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .launchReq(launchReq), .sizeZero(sizeZero),
    .halfRate(halfRate), .slowTick(slowTick), .memAck(memAck),
    .lastStep(lastStep), .strb(strb), .memReq(memReq), .memWe(memWe),
    .busy(busy), .doneIrq(doneIrq)
  );

  blit_datapath #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .STRIDE(STRIDE)) uData (
    .clk(clk), .rstN(rstN), .regWe(acceptWe), .regSel(regSel),
    .regWdata(regWdata), .strb(strb), .writePhase(memWe),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memNibbleEn(memNibbleEn), .lastStep(lastStep), .sizeZero(sizeZero),
    .halfRate(halfRate)
  );
endmodule

// File: rtl/pixel_blitter_checker.sv
module pixel_blitter_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [1:0]        memNibbleEn,
  input logic              busy,
  input logic              doneIrq,
  input logic              slowTick,
  input logic [7:0]        ctrlByte
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr));

  assert_irq_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  assert_busy_drop_R12: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !busy);

  assert_half_rate_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memReq && memWe) && ctrlByte[2]) |-> $past(slowTick));

  assert_dual_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && ctrlByte[7] && ctrlByte[6]) |-> (memNibbleEn == 2'b00));
endmodule

bind pixel_blitter pixel_blitter_checker #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .memNibbleEn(memNibbleEn), .busy(busy),
  .doneIrq(doneIrq), .slowTick(slowTick), .ctrlByte(uData.ctrlReg)
);

// File: tb/pixel_blitter_test.sv
`timescale 1ns/1ps
module pixel_blitter_test;
  localparam int AW = 12, DW = 6, ST = 16, MSZ = 4096;
  localparam int SRC = 'h100, DST = 'h800;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, regWe, slowTick, memReq, memWe, memAck, busy, doneIrq;
  logic [2:0] regSel;
  logic [AW-1:0] regWdata, memAddr;
  logic [7:0] memWdata, memRdata;
  logic [1:0] memNibbleEn;

  pixel_blitter #(.ADDR_W(AW), .DIM_W(DW), .STRIDE(ST)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .slowTick(slowTick), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memNibbleEn(memNibbleEn), .memRdata(memRdata),
    .memAck(memAck), .busy(busy), .doneIrq(doneIrq)
  );

  logic [7:0] mem [0:MSZ-1];
  logic [7:0] img [0:MSZ-1];
  logic [7:0] expMem [0:MSZ-1];
  int checks = 0, fails = 0, irqCount = 0, accessCount = 0, cycleCnt = 0;
  bit finished = 0;

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (doneIrq) irqCount <= irqCount + 1;
    if (!rstN) memAck <= 1'b0;
    else if (memReq && !memAck) begin
      memAck <= 1'b1;
      accessCount <= accessCount + 1;
      if (memWe) begin
        if (memNibbleEn[1]) mem[memAddr][7:4] <= memWdata[7:4];
        if (memNibbleEn[0]) mem[memAddr][3:0] <= memWdata[3:0];
      end else memRdata <= mem[memAddr];
    end else memAck <= 1'b0;
  end

  always @(negedge clk) slowTick <= ~slowTick;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic initMem(input int seed);
    for (int a = 0; a < MSZ; a++) begin
      img[a] = 8'((a * 29 + seed * 13) ^ (a >> 3));
      mem[a] = img[a];
      expMem[a] = img[a];
    end
  endtask

  // arithmetic model of the requirements
  task automatic modelBlit(input logic [7:0] c, input int src, input int dst,
                           input int w, input int h, input logic [3:0] col);
    for (int i = 0; i < h; i++) begin
      logic [3:0] carry;
      carry = 4'd0;
      for (int j = 0; j < w; j++) begin
        int so, dof;
        logic [7:0] s, sh, wd;
        so  = c[0] ? j * ST + i : i * w + j;
        dof = c[1] ? j * ST + i : i * w + j;
        s   = img[src + so];
        sh  = c[5] ? {carry, s[7:4]} : s;
        carry = s[3:0];
        wd  = c[4] ? {col, col} : sh;
        if (!c[6] && !(c[3] && sh[7:4] == 4'd0)) expMem[dst + dof][7:4] = wd[7:4];
        if (!c[7] && !(c[3] && sh[3:0] == 4'd0)) expMem[dst + dof][3:0] = wd[3:0];
      end
    end
  endtask

  function automatic int countDiff();
    int n = 0;
    for (int a = 0; a < MSZ; a++) if (mem[a] !== expMem[a]) n++;
    return n;
  endfunction

  task automatic regWrite(input logic [2:0] sel, input int data);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = AW'(data);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    for (int k = 0; k < 3000; k++) begin
      if (!busy) return;
      @(negedge clk);
    end
    check(0, tag, 1, 0);
  endtask

  task automatic loadRegs(input int src, input int dst, input int w, input int h,
                          input logic [3:0] col);
    regWrite(3'd0, src);
    regWrite(3'd1, dst);
    regWrite(3'd2, (h << DW) | w);
    regWrite(3'd3, int'(col));
  endtask

  task automatic startAndWait(input logic [7:0] c, output int cycles);
    int t0;
    t0 = cycleCnt;
    regWrite(3'd4, int'(c));
    waitIdle("R12 busy never dropped");
    cycles = cycleCnt - t0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 1, 0);
    finishRun();
  end

  initial begin
    int cyc, cycA, cycB, irq0, acc0;
    rstN = 1'b0; regWe = 1'b0; regSel = '0; regWdata = '0; slowTick = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !memReq && !doneIrq, "R1 reset idle", {busy, memReq, doneIrq}, 0);

    // sweep of every control byte: R3 R4 R5 R7 R8 R9 R10 R11 R12
    for (int c = 0; c < 256; c++) begin
      int w, h;
      logic [3:0] col;
      w = 3 + c % 3; h = 2 + c % 2; col = 4'(c) ^ 4'h5;
      initMem(c);
      modelBlit(8'(c), SRC, DST, w, h, col);
      loadRegs(SRC, DST, w, h, col);
      irq0 = irqCount;
      startAndWait(8'(c), cyc);
      check(countDiff() == 0, $sformatf("R3 R4 R5 R7 R8 R9 R11 memory ctrl=%0h", c), countDiff(), 0);
      check(irqCount - irq0 == 1, "R12 one completion pulse", irqCount - irq0, 1);
    end

    // R6: both masks, same duration, nothing written
    initMem(300);
    loadRegs(SRC, DST, 4, 3, 4'h9);
    startAndWait(8'h00, cycA);
    initMem(300);
    startAndWait(8'hC0, cycB);
    check(cycA == cycB, "R6 masked run duration", cycB, cycA);
    check(countDiff() == 0, "R6 masked run writes nothing", countDiff(), 0);

    // R10: half rate costs at least one cycle per byte
    initMem(301);
    startAndWait(8'h04, cycB);
    check(cycB >= cycA + 12, "R10 half-rate slower", cycB, cycA + 12);

    // R13: zero width, then zero height
    acc0 = accessCount; irq0 = irqCount;
    loadRegs(SRC, DST, 0, 3, 4'h1);
    startAndWait(8'h00, cyc);
    check(accessCount == acc0, "R13 zero width no access", accessCount - acc0, 0);
    check(irqCount - irq0 == 1, "R13 zero width pulse", irqCount - irq0, 1);
    acc0 = accessCount;
    loadRegs(SRC, DST, 4, 0, 4'h1);
    startAndWait(8'h00, cyc);
    check(accessCount == acc0, "R13 zero height no access", accessCount - acc0, 0);

    // R2: writes while busy are dropped
    initMem(302);
    modelBlit(8'h00, SRC, DST, 5, 3, 4'h2);
    loadRegs(SRC, DST, 5, 3, 4'h2);
    irq0 = irqCount;
    regWrite(3'd4, 8'h00);
    regWrite(3'd1, DST + 'h200);
    regWrite(3'd4, 8'h10);
    waitIdle("R2 busy never dropped");
    check(countDiff() == 0, "R2 busy writes ignored", countDiff(), 0);
    check(irqCount - irq0 == 1, "R2 no second start", irqCount - irq0, 1);
    initMem(303);
    modelBlit(8'h00, SRC, DST, 5, 3, 4'h2);
    startAndWait(8'h00, cyc);
    check(countDiff() == 0, "R2 earlier destination kept", countDiff(), 0);
    check(!busy && !memReq, "R1 quiet when idle", {busy, memReq}, 0);

    finishRun();
  end
endmodule